// File: doc/BRIEF.md
# PCI Target Exclusive-Access Lock Tracker

This block sits beside the bus-cycle engine of a PCI target. It watches the shared bus controls (frame, lock, initiator-ready and target-ready) and the target's own address-decode hit. From these it decides, once per transaction, whether the target claims the access or answers it with retry. It also keeps the target's exclusive-access state.

The target becomes exclusively owned only when an access it claimed completes its first data phase while the lock line is held. It stays owned across any number of later transactions and idle cycles. The owner comes back with the lock line negated during its address phase, and that access is claimed. Any other initiator that drives lock during its address phase to this target gets a single retry pulse, and no data moves. When the target is not owned, the lock line plays no part in the claim decision. Ownership ends at the first clock edge where both frame and lock are seen negated, or on a synchronous reset.

All bus inputs are active-high in this block. Any inversion of the active-low bus pins is done outside it.

Top module: `pci_lock_tracker`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears locked, claim and retry to 0 after that edge, even while the lock line is held.
- R2: An address phase is the first cycle with frame high after the bus became idle. When the hit input is high and the access is not retried, claim goes high after that edge. It stays high until the edge at which frame and irdy are both seen low, and goes low after that edge.
- R3: An address phase with the hit input low produces neither claim nor retry.
- R4: The locked output goes high after the edge at which claim, irdy, trdy and lock are all high. This applies even when frame is still high (first of several data phases).
- R5: While locked, the locked output stays high through every edge at which frame or lock is high. It goes low after the first edge at which both are low.
- R6: While locked, an address phase with hit and lock both high gives retry = 1 for exactly the next cycle, and claim stays 0.
- R7: retry is never high in two consecutive cycles.
- R8: While not locked, the lock level at the address phase has no effect: a hit is claimed either way.
- R9: A transaction that is not claimed, or a claimed one whose first data phase never completes (trdy low), leaves locked at 0, even with the lock line held.
- R10: While locked, an address phase with hit high and lock low (the owner's access) is claimed, and locked stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_frame | input | 1 | Frame asserted (active high) |
| bus_lock | input | 1 | Lock line asserted (active high) |
| bus_irdy | input | 1 | Initiator ready asserted |
| bus_trdy | input | 1 | Target ready asserted |
| addr_hit | input | 1 | Address decode of this target matched |
| locked | output | 1 | Target is exclusively owned |
| claim | output | 1 | Target claims the current transaction |
| retry | output | 1 | One-cycle request to terminate with retry |

## Verification
The bench sweeps every combination of prior ownership, lock level at the address phase, and decode hit. For each one it checks claim, retry and locked cycle by cycle through the address phase, the data phase, the idle cycle and the release. A design that used the lock level while unowned would wrongly retry a plain locked first access. A design that set ownership at the address phase instead of at data completion would lock on an access that never moved data; the retried-before-data and unclaimed-with-trdy cases are there to catch this. Separate cases check ownership entry while frame is still high, a second retry pulse that a sloppy decoder would emit, and a reset that must win over a held lock line.

// File: rtl/pci_lock_pkg.sv
package pci_lock_pkg;

    // Transaction boundary tracker state
    typedef struct packed {
        logic in_txn;
    } phase_st_t;

    // Response decision state
    typedef struct packed {
        logic claim;
        logic retry;
    } resp_st_t;

    // Exclusive ownership state
    typedef struct packed {
        logic locked;
    } own_st_t;

    typedef enum logic [1:0] {
        DEC_NONE  = 2'd0,
        DEC_CLAIM = 2'd1,
        DEC_RETRY = 2'd2
    } decision_e;

endpackage

// File: rtl/pci_lock_phase.sv
module pci_lock_phase
    import pci_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame,
    input  logic irdy,
    output logic addr_phase,
    output logic txn_end
);

    phase_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        addr_phase = frame && !st_q.in_txn;
        txn_end    = st_q.in_txn && !frame && !irdy;
        if (rst) begin
            st_d = '0;
        end else if (addr_phase) begin
            st_d.in_txn = 1'b1;
        end else if (txn_end) begin
            st_d.in_txn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Only one address phase per transaction (R2)
    p_single_addr_r2: assert property (@(posedge clk) disable iff (rst)
        addr_phase |=> !addr_phase);

endmodule

// File: rtl/pci_lock_resp.sv
module pci_lock_resp
    import pci_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_phase,
    input  logic txn_end,
    input  logic hit,
    input  logic lock,
    input  logic locked,
    output logic claim,
    output logic retry
);

    resp_st_t  st_d, st_q;
    decision_e dec;

    always_comb begin
        dec = DEC_NONE;
        if (addr_phase && hit) begin
            dec = (locked && lock) ? DEC_RETRY : DEC_CLAIM;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.retry = 1'b0;
        if (rst) begin
            st_d = '0;
        end else if (addr_phase) begin
            st_d.claim = (dec == DEC_CLAIM);
            st_d.retry = (dec == DEC_RETRY);
        end else if (txn_end) begin
            st_d.claim = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign claim = st_q.claim;
    assign retry = st_q.retry;

    p_nohit_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && !hit) |=> (!claim && !retry));

    p_foreign_r6: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && hit && locked && lock) |=> (retry && !claim));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(claim && retry));

    p_retry_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        retry |=> !retry);

    p_free_claim_r8: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && hit && !locked) |=> claim);

    p_owner_claim_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && hit && !lock) |=> claim);

endmodule

// File: rtl/pci_lock_own.sv
module pci_lock_own
    import pci_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame,
    input  logic lock,
    input  logic irdy,
    input  logic trdy,
    input  logic claim,
    output logic locked
);

    own_st_t st_d, st_q;
    logic    grab;
    logic    drop;

    always_comb begin
        grab = claim && irdy && trdy && lock;
        drop = !frame && !lock;
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (drop) begin
            st_d.locked = 1'b0;
        end else if (grab) begin
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign locked = st_q.locked;

    p_enter_r4: assert property (@(posedge clk) disable iff (rst)
        (claim && irdy && trdy && lock) |=> locked);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && (frame || lock)) |=> locked);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!frame && !lock) |=> !locked);

    p_no_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (!locked && !claim) |=> !locked);

endmodule

// File: rtl/pci_lock_tracker.sv
module pci_lock_tracker
    import pci_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_frame,
    input  logic bus_lock,
    input  logic bus_irdy,
    input  logic bus_trdy,
    input  logic addr_hit,
    output logic locked,
    output logic claim,
    output logic retry
);

    logic addr_phase;
    logic txn_end;

    pci_lock_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .frame      (bus_frame),
        .irdy       (bus_irdy),
        .addr_phase (addr_phase),
        .txn_end    (txn_end)
    );

    pci_lock_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .addr_phase (addr_phase),
        .txn_end    (txn_end),
        .hit        (addr_hit),
        .lock       (bus_lock),
        .locked     (locked),
        .claim      (claim),
        .retry      (retry)
    );

    pci_lock_own u_own (
        .clk    (clk),
        .rst    (rst),
        .frame  (bus_frame),
        .lock   (bus_lock),
        .irdy   (bus_irdy),
        .trdy   (bus_trdy),
        .claim  (claim),
        .locked (locked)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!locked && !claim && !retry));

endmodule

// File: tb/test_pci_lock_tracker.sv
module test_pci_lock_tracker;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame = 1'b0, lock = 1'b0, irdy = 1'b0, trdy = 1'b0, hit = 1'b0;
    logic locked, claim, retry;
    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;

    always #5 clk = ~clk;

    pci_lock_tracker i_pci_lock_tracker (
        .clk       (clk),
        .rst       (rst),
        .bus_frame (frame),
        .bus_lock  (lock),
        .bus_irdy  (irdy),
        .bus_trdy  (trdy),
        .addr_hit  (hit),
        .locked    (locked),
        .claim     (claim),
        .retry     (retry)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one cycle, then sample just after the edge
    task automatic drive(input logic f, input logic l, input logic i,
                         input logic t, input logic h);
        @(negedge clk);
        frame = f; lock = l; irdy = i; trdy = t; hit = h;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        check("R1 locked", locked, 1'b0);
        check("R1 claim", claim, 1'b0);
        check("R1 retry", retry, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        // Sweep ownership x lock level at address phase x decode hit
        for (int s = 0; s < 2; s++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int h = 0; h < 2; h++) begin
                    logic ec, er, el;
                    do_reset();
                    if (s == 1) begin
                        drive(1, 0, 0, 0, 1);
                        drive(0, 1, 1, 1, 0);
                        drive(0, 1, 0, 0, 0);
                        check("R4 established", locked, 1'b1);
                    end
                    drive(0, 1, 0, 0, 0);
                    ec = (h == 1) && !((s == 1) && (lk == 1));
                    er = (h == 1) && (s == 1) && (lk == 1);
                    el = (s == 1) || ec;
                    drive(1, lk[0], 0, 0, h[0]);
                    check(h == 0 ? "R3 claim" : (s == 0 ? "R8 claim" : "R10/R6 claim"), claim, ec);
                    check(h == 0 ? "R3 retry" : "R6 retry", retry, er);
                    check("R5 locked at addr", locked, s[0]);
                    drive(0, 1, 1, 1, 0);
                    check("R7 retry single", retry, 1'b0);
                    check("R2 claim held", claim, ec);
                    check((s == 0 && !ec) ? "R9 no entry" : "R4/R10 locked", locked, el);
                    drive(0, 1, 0, 0, 0);
                    check("R2 claim end", claim, 1'b0);
                    check("R5 held by lock", locked, el);
                    drive(0, 0, 0, 0, 0);
                    check("R5 release", locked, 1'b0);
                end
            end
        end

        // R9: claimed, but first data phase never completes
        do_reset();
        drive(1, 0, 0, 0, 1);
        drive(0, 1, 1, 0, 0);
        check("R9 no data", locked, 1'b0);
        drive(0, 0, 0, 0, 0);
        check("R9 after end", locked, 1'b0);
        check("R2 claim end", claim, 1'b0);

        // R4: entry on first of several data phases, then foreign retry
        do_reset();
        drive(1, 0, 0, 0, 1);
        drive(1, 1, 1, 1, 0);
        check("R4 multi-phase entry", locked, 1'b1);
        drive(0, 1, 1, 1, 0);
        drive(0, 1, 0, 0, 0);
        drive(1, 1, 0, 0, 1);
        check("R6 foreign retry", retry, 1'b1);
        check("R6 foreign no claim", claim, 1'b0);
        drive(0, 1, 1, 0, 0);
        check("R7 retry drop", retry, 1'b0);
        drive(0, 1, 0, 0, 0);
        check("R5 still locked", locked, 1'b1);

        // R1: reset wins over a held lock line
        @(negedge clk);
        rst = 1'b1;
        drive(0, 1, 0, 0, 0);
        check("R1 reset while locked", locked, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive(0, 1, 0, 0, 0);
        check("R1 stays clear", locked, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule